// File: doc/BRIEF.md
# Mailbox and doorbell interrupt controller

This register block sits between two bus agents, a host side and a local side. Each side has its own word-addressed read/write port. The block holds eight 32-bit mailbox registers, one doorbell register for each direction, and one shared interrupt control/status word. It drives one interrupt line toward each side. The host side can post messages to the local side through the first four mailboxes, and each such post leaves a status flag behind. Doorbells are sticky bit sets: the sending side raises bits and the receiving side clears them. The block also collects two DMA-channel interrupt inputs and one local interrupt input, and routes each of them to an output through its own enable bit.

Each interrupt line comes from a two-state machine. The states are `IRQ_IDLE` and `IRQ_RAISED`. The transition RAISE moves IDLE to RAISED when the gated request is high at a clock edge. The transition DROP moves RAISED to IDLE when the request is low at a clock edge. The output is high exactly in `IRQ_RAISED`, so every output follows its request one clock later. Read data is also registered: it appears on the clock edge that samples the read strobe and holds until the next read.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, all mailboxes, both doorbells, every control/status bit, both read-data outputs and both interrupt outputs are zero.
- R2: Mailbox n sits at byte address 0x40+4n (n = 0..7). Either side can write it and read it back. If both sides write the same mailbox in one cycle, the host value is stored.
- R3: While control bit 3 is 1, a host write to mailbox n (n = 0..3) sets read-only status bit 28+n. When bit 3 is 0, or for mailboxes 4..7, no status bit is set.
- R4: Status bit 28+n clears when the local side reads mailbox n, or when either side writes the control word with bit 28+n set. A host read does not clear it. A set in the same cycle as a clear leaves the bit at 1.
- R5: A host write to 0x60 ORs its data into the host-to-local doorbell, and a local write to 0x60 clears the bits written as 1. Control bit 20 reads 1 while this doorbell is non-zero. A set and a clear of the same bit in one cycle leave that bit at 1.
- R6: A local write to 0x64 ORs its data into the local-to-host doorbell, and a host write to 0x64 clears the bits written as 1. Control bit 13 reads 1 while this doorbell is non-zero. A set in the same cycle as a clear wins.
- R7: The control word at 0x68 stores only the enable bits 3, 8, 9, 11, 16, 17, 18 and 19. Writes to any other bit are not stored. If both sides write it in one cycle, the host value is stored.
- R8: Control bit 15 reads the local interrupt input, and bits 21 and 22 read the DMA channel 0 and 1 interrupt inputs.
- R9: One cycle after its request, the host interrupt output equals bit 8 AND ((bit 9 AND bit 13) OR (bit 11 AND local interrupt input)).
- R10: One cycle after its request, the local interrupt output equals bit 16 AND ((bit 17 AND bit 20) OR (bit 3 AND any status bit 28..31) OR (bit 18 AND DMA 0 input) OR (bit 19 AND DMA 1 input)).
- R11: Read data is updated only in the cycle after the read strobe, and holds at other times. A read of an address that no register occupies, or of an address not aligned to a word, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | ADDR_W | Host-side byte address |
| h_we | input | 1 | Host-side write strobe |
| h_rd | input | 1 | Host-side read strobe |
| h_wdata | input | DATA_W | Host-side write data |
| h_rdata | output | DATA_W | Host-side registered read data |
| l_addr | input | ADDR_W | Local-side byte address |
| l_we | input | 1 | Local-side write strobe |
| l_rd | input | 1 | Local-side read strobe |
| l_wdata | input | DATA_W | Local-side write data |
| l_rdata | output | DATA_W | Local-side registered read data |
| dma_irq_i | input | 2 | DMA channel interrupt levels |
| lint_i | input | 1 | Local interrupt input level |
| host_irq_o | output | 1 | Interrupt toward the host side |
| local_irq_o | output | 1 | Interrupt toward the local side |

## Verification
Because the two ports run in parallel, a set from one side and a clear from the other can land on the same bit in the same cycle. This happens for each doorbell, for a mailbox status flag (a host post against a local read of the same mailbox), and for writes by both sides to one mailbox or to the control word. The bench drives both ports in a single cycle and then reads the result back. It judges the outcome against the rule that a set beats a clear and the host beats the local side. It also checks that the local read that raced the post still returned the mailbox's old contents.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Byte offsets of the register windows
    localparam int MBOX_BASE  = 'h40;
    localparam int DB_H2L_OFS = 'h60;
    localparam int DB_L2H_OFS = 'h64;
    localparam int CSR_OFS    = 'h68;

    // Control/status bit positions
    localparam int B_MBOX_IE  = 3;
    localparam int B_HOST_EN  = 8;
    localparam int B_HDB_IE   = 9;
    localparam int B_LINT_FWD = 11;
    localparam int B_HDB_ACT  = 13;
    localparam int B_LINT_LVL = 15;
    localparam int B_LOC_EN   = 16;
    localparam int B_LDB_IE   = 17;
    localparam int B_DMA0_IE  = 18;
    localparam int B_DMA1_IE  = 19;
    localparam int B_LDB_ACT  = 20;
    localparam int B_DMA0_ACT = 21;
    localparam int B_DMA1_ACT = 22;
    localparam int B_MBST_LSB = 28;

    localparam logic [31:0] CSR_WMASK =
        (32'd1 << B_MBOX_IE) | (32'd1 << B_HOST_EN) | (32'd1 << B_HDB_IE) |
        (32'd1 << B_LINT_FWD) | (32'd1 << B_LOC_EN) | (32'd1 << B_LDB_IE) |
        (32'd1 << B_DMA0_IE) | (32'd1 << B_DMA1_IE);

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_MBOX = 8,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_mbox,
    output logic [IDX_W-1:0]  mbox_idx,
    output logic              hit_h2l,
    output logic              hit_l2h,
    output logic              hit_csr
);
    localparam logic [ADDR_W-1:0] MB_LO = ADDR_W'(MBOX_BASE);
    localparam logic [ADDR_W-1:0] MB_HI = ADDR_W'(MBOX_BASE + 4 * N_MBOX);

    logic aligned;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        hit_mbox = aligned && (addr >= MB_LO) && (addr < MB_HI);
        mbox_idx = IDX_W'((addr - MB_LO) >> 2);
        hit_h2l  = (addr == ADDR_W'(DB_H2L_OFS));
        hit_l2h  = (addr == ADDR_W'(DB_L2H_OFS));
        hit_csr  = (addr == ADDR_W'(CSR_OFS));
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [DATA_W-1:0] set_bits,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] bits_o,
    output logic              active_o
);
    logic [DATA_W-1:0] bits_q, bits_d;

    // The clear is applied first so that a same-cycle set survives
    always_comb begin
        bits_d = bits_q;
        if (clr_we) bits_d = bits_d & ~clr_bits;
        if (set_we) bits_d = bits_d | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o   = bits_q;
    assign active_o = |bits_q;
endmodule

// File: rtl/mbx_mailbox_bank.sv
module mbx_mailbox_bank #(
    parameter int DATA_W = 32,
    parameter int N_MBOX = 8,
    parameter int N_FLAG = 4,
    parameter int IDX_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           h_wr,
    input  logic [IDX_W-1:0]               h_idx,
    input  logic [DATA_W-1:0]              h_wdata,
    input  logic                           l_wr,
    input  logic                           l_rd,
    input  logic [IDX_W-1:0]               l_idx,
    input  logic [DATA_W-1:0]              l_wdata,
    input  logic                           flag_en,
    input  logic [N_FLAG-1:0]              stat_wclr,
    output logic [N_MBOX-1:0][DATA_W-1:0]  mbox_o,
    output logic [N_FLAG-1:0]              stat_o
);
    logic [N_MBOX-1:0][DATA_W-1:0] mbox_q;
    logic [N_FLAG-1:0]             stat_q;

    for (genvar g = 0; g < N_MBOX; g++) begin : g_mbox
        // Host has priority when both sides hit the same register
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mbox_q[g] <= '0;
            else if (h_wr && (h_idx == IDX_W'(g)))
                mbox_q[g] <= h_wdata;
            else if (l_wr && (l_idx == IDX_W'(g)))
                mbox_q[g] <= l_wdata;
        end
    end

    for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
        logic st_set, st_clr;
        assign st_set = h_wr && (h_idx == IDX_W'(f)) && flag_en;
        assign st_clr = (l_rd && (l_idx == IDX_W'(f))) || stat_wclr[f];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q[f] <= 1'b0;
            else        stat_q[f] <= (stat_q[f] & ~st_clr) | st_set;
        end
    end

    assign mbox_o = mbox_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/mbx_irq_fsm.sv
module mbx_irq_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // RAISE: IDLE -> RAISED on request; DROP: RAISED -> IDLE without it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (req_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!req_i) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int N_MBOX = 8,
    parameter int N_FLAG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_we,
    input  logic              h_rd,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic              l_rd,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic [1:0]        dma_irq_i,
    input  logic              lint_i,
    output logic              host_irq_o,
    output logic              local_irq_o
);
    localparam int IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1;
    localparam logic [DATA_W-1:0] WMASK = DATA_W'(CSR_WMASK);

    // Address decode for each side
    logic             h_hit_mb, h_hit_h2l, h_hit_l2h, h_hit_csr;
    logic             l_hit_mb, l_hit_h2l, l_hit_l2h, l_hit_csr;
    logic [IDX_W-1:0] h_idx, l_idx;

    mbx_port_decode #(.ADDR_W(ADDR_W), .N_MBOX(N_MBOX), .IDX_W(IDX_W)) u_hdec (
        .addr(h_addr), .hit_mbox(h_hit_mb), .mbox_idx(h_idx),
        .hit_h2l(h_hit_h2l), .hit_l2h(h_hit_l2h), .hit_csr(h_hit_csr)
    );

    mbx_port_decode #(.ADDR_W(ADDR_W), .N_MBOX(N_MBOX), .IDX_W(IDX_W)) u_ldec (
        .addr(l_addr), .hit_mbox(l_hit_mb), .mbox_idx(l_idx),
        .hit_h2l(l_hit_h2l), .hit_l2h(l_hit_l2h), .hit_csr(l_hit_csr)
    );

    // Control word: enable bits only
    logic [DATA_W-1:0] csr_en_q;
    logic              h_csr_wr, l_csr_wr;
    assign h_csr_wr = h_we && h_hit_csr;
    assign l_csr_wr = l_we && l_hit_csr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        csr_en_q <= '0;
        else if (h_csr_wr) csr_en_q <= h_wdata & WMASK;
        else if (l_csr_wr) csr_en_q <= l_wdata & WMASK;
    end

    logic [N_FLAG-1:0] stat_wclr;
    always_comb begin
        stat_wclr = '0;
        if (h_csr_wr) stat_wclr = stat_wclr | h_wdata[B_MBST_LSB +: N_FLAG];
        if (l_csr_wr) stat_wclr = stat_wclr | l_wdata[B_MBST_LSB +: N_FLAG];
    end

    // Mailboxes and their status flags
    logic [N_MBOX-1:0][DATA_W-1:0] mbox_q;
    logic [N_FLAG-1:0]             mb_stat;

    mbx_mailbox_bank #(
        .DATA_W(DATA_W), .N_MBOX(N_MBOX), .N_FLAG(N_FLAG), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_we && h_hit_mb), .h_idx(h_idx), .h_wdata(h_wdata),
        .l_wr(l_we && l_hit_mb), .l_rd(l_rd && l_hit_mb), .l_idx(l_idx),
        .l_wdata(l_wdata), .flag_en(csr_en_q[B_MBOX_IE]),
        .stat_wclr(stat_wclr), .mbox_o(mbox_q), .stat_o(mb_stat)
    );

    // Doorbells: host->local set by host, local->host set by local
    logic [DATA_W-1:0] db_h2l_q, db_l2h_q;
    logic              h2l_act, l2h_act;

    mbx_doorbell #(.DATA_W(DATA_W)) u_db_h2l (
        .clk(clk), .rst_n(rst_n),
        .set_we(h_we && h_hit_h2l), .set_bits(h_wdata),
        .clr_we(l_we && l_hit_h2l), .clr_bits(l_wdata),
        .bits_o(db_h2l_q), .active_o(h2l_act)
    );

    mbx_doorbell #(.DATA_W(DATA_W)) u_db_l2h (
        .clk(clk), .rst_n(rst_n),
        .set_we(l_we && l_hit_l2h), .set_bits(l_wdata),
        .clr_we(h_we && h_hit_l2h), .clr_bits(h_wdata),
        .bits_o(db_l2h_q), .active_o(l2h_act)
    );

    // Read view of the control/status word
    logic [DATA_W-1:0] csr_rd;
    always_comb begin
        csr_rd                         = csr_en_q;
        csr_rd[B_HDB_ACT]              = l2h_act;
        csr_rd[B_LINT_LVL]             = lint_i;
        csr_rd[B_LDB_ACT]              = h2l_act;
        csr_rd[B_DMA0_ACT]             = dma_irq_i[0];
        csr_rd[B_DMA1_ACT]             = dma_irq_i[1];
        csr_rd[B_MBST_LSB +: N_FLAG]   = mb_stat;
    end

    logic [DATA_W-1:0] h_rd_val, l_rd_val;
    always_comb begin
        h_rd_val = '0;
        if (h_hit_mb)       h_rd_val = mbox_q[h_idx];
        else if (h_hit_h2l) h_rd_val = db_h2l_q;
        else if (h_hit_l2h) h_rd_val = db_l2h_q;
        else if (h_hit_csr) h_rd_val = csr_rd;
    end

    always_comb begin
        l_rd_val = '0;
        if (l_hit_mb)       l_rd_val = mbox_q[l_idx];
        else if (l_hit_h2l) l_rd_val = db_h2l_q;
        else if (l_hit_l2h) l_rd_val = db_l2h_q;
        else if (l_hit_csr) l_rd_val = csr_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata <= '0;
            l_rdata <= '0;
        end else begin
            if (h_rd) h_rdata <= h_rd_val;
            if (l_rd) l_rdata <= l_rd_val;
        end
    end

    // Interrupt requests and their output machines
    logic host_req, local_req;
    always_comb begin
        host_req  = csr_en_q[B_HOST_EN] &&
                    ((csr_en_q[B_HDB_IE] && l2h_act) ||
                     (csr_en_q[B_LINT_FWD] && lint_i));
        local_req = csr_en_q[B_LOC_EN] &&
                    ((csr_en_q[B_LDB_IE] && h2l_act) ||
                     (csr_en_q[B_MBOX_IE] && (|mb_stat)) ||
                     (csr_en_q[B_DMA0_IE] && dma_irq_i[0]) ||
                     (csr_en_q[B_DMA1_IE] && dma_irq_i[1]));
    end

    mbx_irq_fsm u_host_fsm  (.clk(clk), .rst_n(rst_n), .req_i(host_req),  .irq_o(host_irq_o));
    mbx_irq_fsm u_local_fsm (.clk(clk), .rst_n(rst_n), .req_i(local_req), .irq_o(local_irq_o));

endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int N_FLAG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_we,
    input logic              h_rd,
    input logic [ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0] h_wdata,
    input logic [DATA_W-1:0] h_rdata,
    input logic              host_irq_o,
    input logic              local_irq_o,
    input logic              csr_mbox_ie,
    input logic              csr_host_en,
    input logic              csr_loc_en,
    input logic [DATA_W-1:0] db_h2l,
    input logic [N_FLAG-1:0] mb_stat
);
    p_host_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> $past(csr_host_en));

    p_local_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        local_irq_o |-> $past(csr_loc_en));

    p_db_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(h_we && (h_addr == ADDR_W'(DB_H2L_OFS)))
        |-> ((db_h2l & $past(h_wdata)) == $past(h_wdata)));

    p_stat_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mb_stat & ~$past(mb_stat))) |-> $past(csr_mbox_ie));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(h_rd) |-> $stable(h_rdata));
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_FLAG(N_FLAG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq_o(host_irq_o),
    .local_irq_o(local_irq_o),
    .csr_mbox_ie(csr_en_q[mbx_pkg::B_MBOX_IE]),
    .csr_host_en(csr_en_q[mbx_pkg::B_HOST_EN]),
    .csr_loc_en(csr_en_q[mbx_pkg::B_LOC_EN]),
    .db_h2l(db_h2l_q), .mb_stat(mb_stat)
);

// File: tb/mbx_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_bench;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] h_addr = '0, l_addr = '0;
    logic              h_we = 1'b0, h_rd = 1'b0, l_we = 1'b0, l_rd = 1'b0;
    logic [DATA_W-1:0] h_wdata = '0, l_wdata = '0;
    logic [DATA_W-1:0] h_rdata, l_rdata;
    logic [1:0]        dma_irq_i = 2'b00;
    logic              lint_i = 1'b0;
    logic              host_irq_o, local_irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbx_irq_ctrl u_mbx_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_we(h_we), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_addr(l_addr), .l_we(l_we), .l_rd(l_rd), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .dma_irq_i(dma_irq_i), .lint_i(lint_i),
        .host_irq_o(host_irq_o), .local_irq_o(local_irq_o)
    );

    // {req[3:0], local, write, addr[7:0], data[31:0], expected[31:0]}
    localparam int NV = 36;
    localparam logic [77:0] TBL [NV] = '{
        {4'd2,  1'b0, 1'b1, 8'h40, 32'h11111111, 32'h0},         // R2
        {4'd2,  1'b1, 1'b1, 8'h5C, 32'h77770007, 32'h0},
        {4'd2,  1'b0, 1'b0, 8'h40, 32'h0, 32'h11111111},
        {4'd2,  1'b1, 1'b0, 8'h5C, 32'h0, 32'h77770007},
        {4'd2,  1'b1, 1'b0, 8'h40, 32'h0, 32'h11111111},
        {4'd3,  1'b0, 1'b0, 8'h68, 32'h0, 32'h00000000},         // R3 flags off
        {4'd7,  1'b0, 1'b1, 8'h68, 32'hFFFFFFFF, 32'h0},         // R7
        {4'd7,  1'b1, 1'b0, 8'h68, 32'h0, 32'h000F0B08},
        {4'd3,  1'b0, 1'b1, 8'h44, 32'h22222222, 32'h0},
        {4'd3,  1'b0, 1'b0, 8'h68, 32'h0, 32'h200F0B08},
        {4'd4,  1'b0, 1'b0, 8'h44, 32'h0, 32'h22222222},         // R4 host read
        {4'd4,  1'b0, 1'b0, 8'h68, 32'h0, 32'h200F0B08},
        {4'd4,  1'b1, 1'b0, 8'h44, 32'h0, 32'h22222222},         // local read clears
        {4'd4,  1'b0, 1'b0, 8'h68, 32'h0, 32'h000F0B08},
        {4'd3,  1'b0, 1'b1, 8'h50, 32'h44444444, 32'h0},         // mailbox 4
        {4'd3,  1'b0, 1'b0, 8'h68, 32'h0, 32'h000F0B08},
        {4'd5,  1'b0, 1'b1, 8'h60, 32'h00000005, 32'h0},         // R5
        {4'd5,  1'b1, 1'b0, 8'h60, 32'h0, 32'h00000005},
        {4'd5,  1'b0, 1'b0, 8'h68, 32'h0, 32'h001F0B08},
        {4'd5,  1'b0, 1'b1, 8'h60, 32'h00000012, 32'h0},
        {4'd5,  1'b1, 1'b0, 8'h60, 32'h0, 32'h00000017},
        {4'd5,  1'b1, 1'b1, 8'h60, 32'h00000007, 32'h0},
        {4'd5,  1'b0, 1'b0, 8'h60, 32'h0, 32'h00000010},
        {4'd5,  1'b1, 1'b1, 8'h60, 32'h00000010, 32'h0},
        {4'd5,  1'b1, 1'b0, 8'h68, 32'h0, 32'h000F0B08},
        {4'd6,  1'b1, 1'b1, 8'h64, 32'h00000100, 32'h0},         // R6
        {4'd6,  1'b0, 1'b0, 8'h64, 32'h0, 32'h00000100},
        {4'd6,  1'b0, 1'b0, 8'h68, 32'h0, 32'h000F2B08},
        {4'd6,  1'b0, 1'b1, 8'h64, 32'h00000100, 32'h0},
        {4'd6,  1'b1, 1'b0, 8'h64, 32'h0, 32'h00000000},
        {4'd11, 1'b0, 1'b0, 8'h7C, 32'h0, 32'h00000000},         // R11 unmapped
        {4'd11, 1'b0, 1'b0, 8'h42, 32'h0, 32'h00000000},         // misaligned
        {4'd3,  1'b0, 1'b1, 8'h40, 32'hAAAA5555, 32'h0},
        {4'd3,  1'b1, 1'b0, 8'h68, 32'h0, 32'h100F0B08},
        {4'd4,  1'b1, 1'b1, 8'h68, 32'h100F0B08, 32'h0},         // write-1 clear
        {4'd4,  1'b0, 1'b0, 8'h68, 32'h0, 32'h000F0B08}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); h_addr = a; h_wdata = d; h_we = 1'b1;
        @(negedge clk); h_we = 1'b0;
    endtask

    task automatic lw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); l_addr = a; l_wdata = d; l_we = 1'b1;
        @(negedge clk); l_we = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); h_addr = a; h_rd = 1'b1;
        @(negedge clk); h_rd = 1'b0;
        check(tag, h_rdata, exp);
    endtask

    task automatic lr(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); l_addr = a; l_rd = 1'b1;
        @(negedge clk); l_rd = 1'b0;
        check(tag, l_rdata, exp);
    endtask

    task automatic both(input logic hwe, input logic [7:0] ha, input logic [31:0] hd,
                        input logic lwe, input logic lrd, input logic [7:0] la,
                        input logic [31:0] ld);
        @(negedge clk);
        h_addr = ha; h_wdata = hd; h_we = hwe;
        l_addr = la; l_wdata = ld; l_we = lwe; l_rd = lrd;
        @(negedge clk);
        h_we = 1'b0; l_we = 1'b0; l_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: state after reset
        repeat (3) @(negedge clk);
        check("R1 h_rdata", h_rdata, 32'h0);
        check("R1 l_rdata", l_rdata, 32'h0);
        check("R1 host_irq", {31'b0, host_irq_o}, 32'h0);
        check("R1 local_irq", {31'b0, local_irq_o}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [77:0] v;
            string tag;
            v = TBL[i];
            tag = $sformatf("R%0d table entry %0d", v[77:74], i);
            if (v[72]) begin
                if (v[73]) lw(v[71:64], v[63:32]);
                else       hw(v[71:64], v[63:32]);
            end else begin
                if (v[73]) lr(v[71:64], v[31:0], tag);
                else       hr(v[71:64], v[31:0], tag);
            end
        end

        // R8: input levels visible in the control word
        do_reset();
        lint_i = 1'b1; dma_irq_i = 2'b11;
        hr(8'h68, 32'h00608000, "R8 input levels");
        lint_i = 1'b0; dma_irq_i = 2'b00;

        // R9: host interrupt path
        lint_i = 1'b1;
        hw(8'h68, 32'h00000900);
        check("R9 one-cycle lag", {31'b0, host_irq_o}, 32'h0);
        @(negedge clk);
        check("R9 forwarded input", {31'b0, host_irq_o}, 32'h1);
        lint_i = 1'b0;
        @(negedge clk);
        check("R9 input dropped", {31'b0, host_irq_o}, 32'h0);
        hw(8'h68, 32'h00000300);
        lw(8'h64, 32'h4);
        @(negedge clk);
        check("R9 doorbell raise", {31'b0, host_irq_o}, 32'h1);
        hw(8'h64, 32'h4);
        @(negedge clk);
        check("R9 doorbell cleared", {31'b0, host_irq_o}, 32'h0);
        hw(8'h68, 32'h00000200);
        lw(8'h64, 32'h4);
        @(negedge clk); @(negedge clk);
        check("R9 master off", {31'b0, host_irq_o}, 32'h0);

        // R10: local interrupt path
        do_reset();
        hw(8'h68, 32'h00050000);
        dma_irq_i = 2'b01;
        @(negedge clk);
        check("R10 dma0", {31'b0, local_irq_o}, 32'h1);
        dma_irq_i = 2'b00;
        @(negedge clk);
        check("R10 dma0 dropped", {31'b0, local_irq_o}, 32'h0);
        dma_irq_i = 2'b10;
        @(negedge clk); @(negedge clk);
        check("R10 dma1 not enabled", {31'b0, local_irq_o}, 32'h0);
        dma_irq_i = 2'b00;
        hw(8'h68, 32'h00010008);
        hw(8'h4C, 32'h5);
        @(negedge clk);
        check("R10 mailbox status", {31'b0, local_irq_o}, 32'h1);
        lr(8'h4C, 32'h5, "R4 read mailbox 3");
        check("R10 still raised", {31'b0, local_irq_o}, 32'h1);
        @(negedge clk);
        check("R10 status cleared", {31'b0, local_irq_o}, 32'h0);
        hw(8'h68, 32'h00020000);
        hw(8'h60, 32'h1);
        @(negedge clk); @(negedge clk);
        check("R10 master off", {31'b0, local_irq_o}, 32'h0);
        hw(8'h68, 32'h00030000);
        @(negedge clk);
        check("R10 doorbell raise", {31'b0, local_irq_o}, 32'h1);

        // Same-cycle races between the two ports
        do_reset();
        hw(8'h68, 32'h00000008);
        hw(8'h60, 32'h1);
        both(1'b1, 8'h60, 32'h1, 1'b1, 1'b0, 8'h60, 32'h1);
        lr(8'h60, 32'h1, "R5 set beats clear");
        lw(8'h64, 32'h2);
        both(1'b1, 8'h64, 32'h2, 1'b1, 1'b0, 8'h64, 32'h2);
        hr(8'h64, 32'h2, "R6 set beats clear");
        hw(8'h48, 32'hB0);
        both(1'b1, 8'h48, 32'hB1, 1'b0, 1'b1, 8'h48, 32'h0);
        check("R11 racing read old data", l_rdata, 32'hB0);
        hr(8'h68, 32'h40102008, "R4 post beats read clear");
        both(1'b1, 8'h54, 32'hC, 1'b1, 1'b0, 8'h54, 32'hD);
        lr(8'h54, 32'hC, "R2 host wins mailbox");
        both(1'b1, 8'h68, 32'h8, 1'b1, 1'b0, 8'h68, 32'h00010000);
        hr(8'h68, 32'h40102008, "R7 host wins control");

        // R1: reset in mid-run
        do_reset();
        hr(8'h40, 32'h0, "R1 mailbox after reset");
        hr(8'h68, 32'h0, "R1 control after reset");
        lr(8'h60, 32'h0, "R1 doorbell after reset");
        check("R1 irqs after reset", {30'b0, host_irq_o, local_irq_o}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule